// File: doc/BRIEF.md
# Programmable Receive Address Match Entry

This block is a single programmable slot of an Ethernet receive address filter. The first twelve header bytes of each incoming frame arrive one byte per cycle. The entry compares either the destination address (header bytes 0 to 5) or the source address (header bytes 6 to 11) against a 48-bit address that software has written. A per-byte mask removes chosen address bytes from the comparison. With bytes masked, one entry accepts a whole group of addresses.

Software programs the entry through a 32-bit write port that has two words. The low word holds address bits 31:0. The high word holds address bits 47:32 together with the control fields. The result is registered: it becomes visible one cycle after the last byte of the chosen field and stays until the next start of frame. A surrounding filter can combine several such entries.

Top module: `maf_entry`

## Requirements
- R1: After reset, the entry is disabled, so a frame produces `match_valid`=1 with `match`=0.
- R2: While the enable bit (high word bit 31) is 0, `match` stays 0 whatever the address and mask contents are.
- R3: When the source-select bit (high word bit 30) is 0, the programmed address is compared with header bytes 0..5. `match_valid` rises in the cycle after byte 5 is accepted and is 0 before that.
- R4: When the source-select bit is 1, the comparison uses header bytes 6..11. `match_valid` rises in the cycle after byte 11 is accepted and is 0 before that.
- R5: The first byte of the selected field is compared with address bits 7:0, and byte k of the field is compared with address bits 8k+7:8k.
- R6: The byte-mask field sits in high word bits 29:24. Mask bit k, when set, excludes address bits 8k+7:8k (field byte k) from the comparison. High word bits 15:0 are address bits 47:32, and low word (`cfg_word`=0) bits 31:0 are address bits 31:0.
- R7: When the entry is enabled and all six mask bits are set, every frame reports `match`=1.
- R8: `match_valid` and `match` hold their values until a byte with `rx_sof`=1 is accepted. In the following cycle both read 0.
- R9: The address resets to all ones: high part 0xFFFF, low part 0xFFFFFFFF.
- R10: Cycles with `rx_valid`=0 are ignored. Idle gaps between header bytes change neither the byte position nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_word | input | 1 | Word select: 0 = address low, 1 = address high plus control |
| cfg_wdata | input | 32 | Configuration write data |
| rx_valid | input | 1 | Header byte valid |
| rx_sof | input | 1 | First header byte of a frame, qualified by rx_valid |
| rx_data | input | 8 | Header byte |
| match_valid | output | 1 | Result of the selected field is available |
| match | output | 1 | Selected field matched the programmed address |

## Verification
A wrong byte position shows up as `match_valid` rising one or more cycles early or late, relative to the last byte of the chosen field. A stuck accumulator shows up as a wrong `match` value in that same cycle. A corrupted mask bit or a swapped byte order shows up only when the differing byte is unmasked, so the frames cross every mask value with single-byte and multi-byte differences. Every such error appears at the ports one cycle after the sixth byte of the field, and the hold and clear checks follow on the next start of frame.

// File: rtl/maf_pkg.sv
package maf_pkg;
  localparam int unsigned MAF_ADDR_BYTES = 6;
  localparam int unsigned MAF_WORD_W     = 32;
  localparam int unsigned MAF_MASK_LSB   = 24;
  localparam int unsigned MAF_SRC_BIT    = 30;
  localparam int unsigned MAF_EN_BIT     = 31;
endpackage

// File: rtl/maf_cfg_regs.sv
module maf_cfg_regs #(
  parameter int unsigned N_BYTES  = maf_pkg::MAF_ADDR_BYTES,
  parameter int unsigned WORD_W   = maf_pkg::MAF_WORD_W,
  parameter int unsigned MASK_LSB = maf_pkg::MAF_MASK_LSB,
  parameter int unsigned SRC_BIT  = maf_pkg::MAF_SRC_BIT,
  parameter int unsigned EN_BIT   = maf_pkg::MAF_EN_BIT
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic                   word,
  input  logic [WORD_W-1:0]      wdata,
  output logic                   en,
  output logic                   use_src,
  output logic [N_BYTES-1:0]     mask,
  output logic [8*N_BYTES-1:0]   addr
);
  localparam int unsigned AW = 8 * N_BYTES;
  localparam int unsigned HW = AW - WORD_W;

  logic [WORD_W-1:0] addr_lo;
  logic [HW-1:0]     addr_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_lo <= '1;
      addr_hi <= '1;
      en      <= 1'b0;
      use_src <= 1'b0;
      mask    <= '0;
    end else if (we) begin
      if (!word) begin
        addr_lo <= wdata;
      end else begin
        addr_hi <= wdata[HW-1:0];
        mask    <= wdata[MASK_LSB +: N_BYTES];
        use_src <= wdata[SRC_BIT];
        en      <= wdata[EN_BIT];
      end
    end
  end

  assign addr = {addr_hi, addr_lo};
endmodule

// File: rtl/maf_byte_index.sv
module maf_byte_index #(
  parameter int unsigned N_BYTES = maf_pkg::MAF_ADDR_BYTES,
  localparam int unsigned HDR    = 2 * N_BYTES,
  localparam int unsigned IW     = $clog2(HDR + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic          rx_sof,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] cnt;

  assign idx = rx_sof ? '0 : cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= IW'(HDR);
    end else if (rx_valid && (idx != IW'(HDR))) begin
      cnt <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/maf_field_cmp.sv
module maf_field_cmp #(
  parameter int unsigned N_BYTES = maf_pkg::MAF_ADDR_BYTES,
  localparam int unsigned HDR    = 2 * N_BYTES,
  localparam int unsigned IW     = $clog2(HDR + 1),
  localparam int unsigned AW     = 8 * N_BYTES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rx_valid,
  input  logic               rx_sof,
  input  logic [7:0]         rx_data,
  input  logic [IW-1:0]      idx,
  input  logic               en,
  input  logic               use_src,
  input  logic [N_BYTES-1:0] mask,
  input  logic [AW-1:0]      addr,
  output logic               match_valid,
  output logic               match
);
  logic [N_BYTES-1:0] byte_hit;
  logic [IW-1:0]      start;
  logic [IW-1:0]      kidx;
  logic               in_field;
  logic               last;
  logic               byte_ok;
  logic               acc;
  logic               acc_in;

  for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
    assign byte_hit[k] = mask[k] | (rx_data == addr[8*k +: 8]);
  end

  assign start    = use_src ? IW'(N_BYTES) : '0;
  assign kidx     = idx - start;
  assign in_field = (idx >= start) && (idx < start + IW'(N_BYTES));
  assign last     = in_field && (kidx == IW'(N_BYTES - 1));
  assign acc_in   = rx_sof ? 1'b1 : acc;

  always_comb begin
    byte_ok = 1'b0;
    for (int k = 0; k < N_BYTES; k++) begin
      if (kidx == IW'(k)) byte_ok = byte_hit[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc         <= 1'b1;
      match_valid <= 1'b0;
      match       <= 1'b0;
    end else if (rx_valid) begin
      if (rx_sof) begin
        match_valid <= 1'b0;
        match       <= 1'b0;
      end
      acc <= in_field ? (acc_in & byte_ok) : acc_in;
      if (last) begin
        match_valid <= 1'b1;
        match       <= en & acc_in & byte_ok;
      end
    end
  end

  // R8: start of frame clears the result in the next cycle
  a_r8_sof_clears: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_sof) |=> (!match_valid && !match));
  // R8: result held while no start of frame arrives
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (match_valid && !(rx_valid && rx_sof)) |=> (match_valid && $stable(match)));
  // R10: idle cycles leave the outputs untouched
  a_r10_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> ($stable(match_valid) && $stable(match)));
  // R3: the result only appears after an accepted byte
  a_r3_rise_on_byte: assert property (@(posedge clk) disable iff (rst)
    $rose(match_valid) |-> $past(rx_valid));
endmodule

// File: rtl/maf_entry.sv
module maf_entry #(
  parameter int unsigned N_BYTES = maf_pkg::MAF_ADDR_BYTES,
  parameter int unsigned WORD_W  = maf_pkg::MAF_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_word,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic [7:0]        rx_data,
  output logic              match_valid,
  output logic              match
);
  localparam int unsigned HDR = 2 * N_BYTES;
  localparam int unsigned IW  = $clog2(HDR + 1);
  localparam int unsigned AW  = 8 * N_BYTES;

  logic               en;
  logic               use_src;
  logic [N_BYTES-1:0] mask;
  logic [AW-1:0]      addr;
  logic [IW-1:0]      idx;

  maf_cfg_regs #(.N_BYTES(N_BYTES), .WORD_W(WORD_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .word(cfg_word), .wdata(cfg_wdata),
    .en(en), .use_src(use_src), .mask(mask), .addr(addr)
  );

  maf_byte_index #(.N_BYTES(N_BYTES)) u_idx (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .idx(idx)
  );

  maf_field_cmp #(.N_BYTES(N_BYTES)) u_cmp (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_data(rx_data), .idx(idx), .en(en), .use_src(use_src),
    .mask(mask), .addr(addr), .match_valid(match_valid), .match(match)
  );

  // R2: a disabled entry never raises a match
  a_r2_disabled_no_match: assert property (@(posedge clk) disable iff (rst)
    (!en && !cfg_we && $rose(match_valid)) |-> !match);
  // R7: all bytes masked and enabled gives a match on each result
  a_r7_full_mask: assert property (@(posedge clk) disable iff (rst)
    (en && (&mask) && !cfg_we && $rose(match_valid)) |-> match);
  // R8: match is never reported without a valid result
  a_r8_match_needs_valid: assert property (@(posedge clk) disable iff (rst)
    match |-> match_valid);
endmodule

// File: tb/test_maf_entry.sv
module test_maf_entry;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we, cfg_word;
  logic [31:0] cfg_wdata;
  logic        rx_valid, rx_sof;
  logic [7:0]  rx_data;
  logic        match_valid, match;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  maf_entry i_maf_entry (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_word(cfg_word),
    .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_data(rx_data), .match_valid(match_valid), .match(match)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input bit word, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_word = word; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] hi_word(input bit en, input bit src,
                                          input logic [5:0] msk, input logic [15:0] ahi);
    return {en, src, msk, 8'h00, ahi};
  endfunction

  // Sends 12 header bytes; checks valid low before field end, result after, hold, and sof clear.
  task automatic send_frame(input logic [47:0] da, input logic [47:0] sa, input bit src,
                            input bit gaps, input bit exp, input string req);
    int  last = src ? 11 : 5;
    bit  pre_ok = 1;
    for (int i = 0; i < 12; i++) begin
      if (gaps && (i % 2 == 1)) begin
        rx_valid = 1'b0; rx_sof = 1'b0;
        @(negedge clk);
        if (i > last) check(match_valid === 1'b1 && match === exp, "R10 gap hold", match, exp);
        else if (match_valid !== 1'b0) pre_ok = 0;
      end
      rx_valid = 1'b1;
      rx_sof   = (i == 0);
      rx_data  = (i < 6) ? da[8*i +: 8] : sa[8*(i-6) +: 8];
      @(negedge clk);
      if (i == 0) check(match_valid === 1'b0 && match === 1'b0, "R8 sof clear", match_valid, 0);
      else if (i < last && match_valid !== 1'b0) pre_ok = 0;
      if (i == last) begin
        check(pre_ok, src ? "R4 early valid" : "R3 early valid", 0, 1);
        check(match_valid === 1'b1, src ? "R4 valid" : "R3 valid", match_valid, 1);
        check(match === exp, req, match, exp);
      end
    end
    rx_valid = 1'b0; rx_sof = 1'b0;
    @(negedge clk);
    check(match_valid === 1'b1 && match === exp, "R8 hold", match, exp);
  endtask

  localparam logic [47:0] A = 48'hB4_07_E2_91_3C_5A;

  function automatic logic [47:0] apply_diff(input logic [47:0] a, input logic [5:0] d);
    logic [47:0] r = a;
    for (int k = 0; k < 6; k++) if (d[k]) r[8*k +: 8] = a[8*k +: 8] ^ 8'h81;
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [5:0] diffs [10] = '{6'd0, 6'd1, 6'd2, 6'd4, 6'd8, 6'd16, 6'd32, 6'd63, 6'd5, 6'd40};
    rst = 1'b1; cfg_we = 1'b0; cfg_word = 1'b0; cfg_wdata = '0;
    rx_valid = 1'b0; rx_sof = 1'b0; rx_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(match_valid === 1'b0 && match === 1'b0, "R1 reset outputs", match, 0);

    // R1: disabled after reset, even though the DA equals the reset address
    send_frame('1, '1, 1'b0, 1'b0, 1'b0, "R1 disabled after reset");
    // R9: low word untouched keeps all ones
    cfg_write(1'b1, hi_word(1'b1, 1'b0, 6'h00, 16'hFFFF));
    send_frame('1, 48'h0, 1'b0, 1'b0, 1'b1, "R9 reset address low");
    send_frame(48'hFFFF_FFFF_FFFE, 48'h0, 1'b0, 1'b0, 1'b0, "R9 low byte differs");

    // Sweep: mask x difference pattern x field select, enabled (R3 R4 R5 R6 R7)
    cfg_write(1'b0, A[31:0]);
    for (int s = 0; s < 2; s++) begin
      for (int m = 0; m < 64; m++) begin
        cfg_write(1'b1, hi_word(1'b1, s[0], m[5:0], A[47:32]));
        for (int d = 0; d < 10; d++) begin
          logic [47:0] fld = apply_diff(A, diffs[d]);
          bit exp = ((diffs[d] & ~m[5:0]) == 6'd0);
          if (s == 0) send_frame(fld, ~A, 1'b0, 1'b0, exp, "R6 R5 mask sweep DA");
          else        send_frame(~A, fld, 1'b1, 1'b0, exp, "R6 R5 mask sweep SA");
        end
      end
    end

    // R7: all masked, arbitrary frames
    cfg_write(1'b1, hi_word(1'b1, 1'b1, 6'h3F, A[47:32]));
    send_frame(48'h0, 48'h1234_5678_9ABC, 1'b1, 1'b0, 1'b1, "R7 all masked");
    send_frame(48'hDEAD_BEEF_0001, 48'h0, 1'b1, 1'b1, 1'b1, "R7 all masked gaps");

    // R5: byte order reversed must not match
    cfg_write(1'b1, hi_word(1'b1, 1'b0, 6'h00, A[47:32]));
    send_frame({A[7:0], A[15:8], A[23:16], A[31:24], A[39:32], A[47:40]}, A, 1'b0, 1'b0,
               1'b0, "R5 reversed order");

    // R10: gaps between bytes, both fields
    send_frame(A, ~A, 1'b0, 1'b1, 1'b1, "R10 gaps DA");
    cfg_write(1'b1, hi_word(1'b1, 1'b1, 6'h00, A[47:32]));
    send_frame(~A, A, 1'b1, 1'b1, 1'b1, "R10 gaps SA");
    send_frame(A, ~A, 1'b1, 1'b0, 1'b0, "R4 SA select ignores DA");

    // R2: disabled with any mask and exact address
    for (int m = 0; m < 64; m += 9) begin
      cfg_write(1'b1, hi_word(1'b0, m[0], m[5:0], A[47:32]));
      send_frame(A, A, m[0], 1'b0, 1'b0, "R2 disabled");
    end
    cfg_write(1'b1, hi_word(1'b0, 1'b0, 6'h3F, A[47:32]));
    send_frame(A, A, 1'b0, 1'b0, 1'b0, "R2 disabled full mask");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule